// File: doc/BRIEF.md
# HDB3/AMI Line Decoder with Code-Rule Checking

This block sits behind a line receiver that has already sliced a ternary line into two unipolar rails: one high for a positive pulse, one high for a negative pulse. On each rising edge of the receive clock it takes one line symbol. It removes the zero-run substitutions that HDB3 inserts and returns the binary data stream. In the same cycle it reports every symbol that breaks the coding rules. A select pin chooses full HDB3 decoding or plain alternate-mark-inversion (AMI) decoding.

A combinational output gives the OR of the two rails, so that an external circuit can recover the clock from it. A loop-test pin feeds the local transmit rails into the decoder in place of the line rails, so that a local encoder can be checked end to end.

Symbols arrive one per clock with no back-pressure. The line cannot be stalled, so no valid/ready pair is provided: every clock carries a symbol and every clock produces one output bit.

Top module: `hdb3_ami_decoder`

## Requirements
- R1: The rails are sampled on the rising clock edge. The decoded bit for a symbol appears on `nrz_out` after the fourth rising edge that follows its sampling edge, and stays there for one clock. A plain mark decodes to 1 and a space decodes to 0.
- R2: `rclk_out` is the OR of the two selected rails, with no register in the path.
- R3: With `loop_en` = 1, the rails `loc_pos`/`loc_neg` take the place of `ext_pos`/`ext_neg`, both for decoding and for `rclk_out`, and the external rails have no effect.
- R4: A single-rail pulse whose polarity is opposite to the last mark is an ordinary mark. It decodes to 1, raises no error, and becomes the new last-mark polarity. `ext_pos`/`loc_pos` carry positive polarity.
- R5: With `hdb3_sel` = 1, a violation is a pulse with the same polarity as the last mark. A violation is a substitution when the symbol four places before it was a pulse and the two symbols just before it were spaces. In that case the violation and its three preceding symbols decode to 0, and the symbol four places back keeps its value. So both `+000+` and `-+00+` decode to `10000`.
- R6: With `hdb3_sel` = 1, a violation that lacks that pattern decodes to 1 and clears no bits. `err_out` stays low for it.
- R7: With `hdb3_sel` = 1, `err_out` rises for a substitution violation whose polarity equals that of the previous violation. Every HDB3 violation, with or without the pattern, updates the last-violation polarity.
- R8: With `hdb3_sel` = 0, every violation raises `err_out` and decodes to 1. No substitution is removed.
- R9: When both rails are high in one symbol, in either mode, the symbol decodes to 1 and `err_out` rises. Neither the last-mark nor the last-violation polarity changes.
- R10: While `rst_n` is low, `nrz_out` and `err_out` are 0 and the window holds only spaces. After reset, both the last-mark and the last-violation polarity are negative.
- R11: `err_out` is high during exactly the one clock that follows the sampling edge of the offending symbol. It is never high unless that symbol carried a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; symbols are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_sel | input | 1 | 1 = HDB3 decoding, 0 = AMI decoding |
| loop_en | input | 1 | 1 = decode the local transmit rails instead of the line rails |
| ext_pos | input | 1 | Line rail, positive pulses |
| ext_neg | input | 1 | Line rail, negative pulses |
| loc_pos | input | 1 | Local transmit rail, positive pulses |
| loc_neg | input | 1 | Local transmit rail, negative pulses |
| rclk_out | output | 1 | OR of the selected rails, for clock recovery |
| nrz_out | output | 1 | Decoded binary data, four clocks behind the symbol |
| err_out | output | 1 | One-clock flag for a code-rule breach |

## Verification
The embedded properties check the rules that hold on every clock:
- a both-rails symbol flags an error and leaves the polarity trackers unchanged;
- an AMI-mode violation always flags;
- an HDB3 violation without the substitution pattern never flags;
- any error traces back to a pulse;
- a decoded 1 traces back to a pulse five samples earlier;
- a removed substitution leaves the whole window cleared.

Only the bench scenarios can show that whole streams decode correctly: `+000+` and `-+00+` both become `10000`, consecutive substitutions must alternate in polarity, the loop path really ignores the line rails, and a random HDB3-encoded payload comes back bit for bit with no error.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;
  // symbols held in the decode window; the substitution rule needs four
  localparam int unsigned WIN_DEPTH  = 4;
  // spaces that must sit just before a violation for it to be removable
  localparam int unsigned ZERO_SLOTS = 2;

  typedef enum logic [1:0] {
    SYM_SPACE = 2'd0,
    SYM_MARK  = 2'd1,
    SYM_VIOL  = 2'd2,
    SYM_DUAL  = 2'd3
  } sym_e;

  typedef struct packed {
    logic pulse;  // a pulse was seen on either rail
    logic data;   // decoded binary value, may still be cleared
  } slot_t;
endpackage

// File: rtl/hdb3_rail_sel.sv
module hdb3_rail_sel (
  input  logic loop_en,
  input  logic ext_p,
  input  logic ext_n,
  input  logic loc_p,
  input  logic loc_n,
  output logic sel_p,
  output logic sel_n,
  output logic rclk
);
  always_comb begin
    if (loop_en) begin
      sel_p = loc_p;
      sel_n = loc_n;
    end else begin
      sel_p = ext_p;
      sel_n = ext_n;
    end
    rclk = sel_p | sel_n;
  end
endmodule

// File: rtl/hdb3_sym_class.sv
module hdb3_sym_class
  import hdb3_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hdb3_sel,
  input  logic  rail_p,
  input  logic  rail_n,
  input  logic  pat_ok,
  output logic  sub_hit,
  output slot_t slot,
  output logic  err_q
);
  logic mark_pos_q;  // 1: last mark was positive
  logic viol_pos_q;  // 1: last violation was positive
  logic same_as_mark;
  logic err_d;
  sym_e sym;

  always_comb begin
    same_as_mark = (rail_p == mark_pos_q);
    unique case ({rail_p, rail_n})
      2'b00:   sym = SYM_SPACE;
      2'b11:   sym = SYM_DUAL;
      default: sym = same_as_mark ? SYM_VIOL : SYM_MARK;
    endcase
  end

  always_comb begin
    sub_hit    = hdb3_sel && (sym == SYM_VIOL) && pat_ok;
    slot.pulse = rail_p | rail_n;
    slot.data  = (sym == SYM_MARK) || (sym == SYM_DUAL) ||
                 ((sym == SYM_VIOL) && !sub_hit);
    err_d      = (sym == SYM_DUAL) ||
                 ((sym == SYM_VIOL) && !hdb3_sel) ||
                 (sub_hit && (rail_p == viol_pos_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_pos_q <= 1'b0;
      viol_pos_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= err_d;
      if ((sym == SYM_MARK) || (sym == SYM_VIOL)) mark_pos_q <= rail_p;
      if ((sym == SYM_VIOL) && hdb3_sel)          viol_pos_q <= rail_p;
    end
  end

  assert_dual_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_p && rail_n) |=> err_q);

  assert_dual_keeps_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_p && rail_n) |=> ($stable(mark_pos_q) && $stable(viol_pos_q)));

  assert_ami_viol_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdb3_sel && (rail_p != rail_n) && (rail_p == mark_pos_q)) |=> err_q);

  assert_bad_pattern_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdb3_sel && (rail_p != rail_n) && (rail_p == mark_pos_q) && !pat_ok) |=> !err_q);

  assert_err_needs_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(rail_p || rail_n));
endmodule

// File: rtl/hdb3_sub_window.sv
module hdb3_sub_window
  import hdb3_dec_pkg::*;
#(
  parameter int unsigned DEPTH = WIN_DEPTH
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t slot_in,
  input  logic  sub_hit,
  output logic  pat_ok,
  output logic  nrz_q
);
  localparam int unsigned OLDEST = DEPTH - 1;
  localparam int unsigned LAT    = DEPTH + 1;

  slot_t win_q [DEPTH];
  logic  gap_clear;
  logic  win_data_any;

  always_comb begin
    gap_clear = 1'b1;
    for (int i = 0; i < int'(ZERO_SLOTS); i++) gap_clear &= ~win_q[i].pulse;
    pat_ok = win_q[OLDEST].pulse & gap_clear;
    win_data_any = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) win_data_any |= win_q[i].data;
  end

  // the oldest slot is the anchor pulse and leaves untouched; the rest clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) win_q[i] <= '0;
      nrz_q <= 1'b0;
    end else begin
      win_q[0] <= slot_in;
      for (int i = 1; i < int'(DEPTH); i++) begin
        win_q[i].pulse <= win_q[i-1].pulse;
        win_q[i].data  <= win_q[i-1].data & ~sub_hit;
      end
      nrz_q <= win_q[OLDEST].data;
    end
  end

  assert_one_needs_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_q |-> $past(slot_in.pulse, LAT));

  assert_sub_clears_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_hit |=> !win_data_any);
endmodule

// File: rtl/hdb3_ami_decoder.sv
module hdb3_ami_decoder
  import hdb3_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_sel,
  input  logic loop_en,
  input  logic ext_pos,
  input  logic ext_neg,
  input  logic loc_pos,
  input  logic loc_neg,
  output logic rclk_out,
  output logic nrz_out,
  output logic err_out
);
  logic  rail_p, rail_n;
  logic  pat_ok, sub_hit;
  slot_t slot;

  hdb3_rail_sel u_sel (
    .loop_en (loop_en),
    .ext_p   (ext_pos),
    .ext_n   (ext_neg),
    .loc_p   (loc_pos),
    .loc_n   (loc_neg),
    .sel_p   (rail_p),
    .sel_n   (rail_n),
    .rclk    (rclk_out)
  );

  hdb3_sym_class u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdb3_sel (hdb3_sel),
    .rail_p   (rail_p),
    .rail_n   (rail_n),
    .pat_ok   (pat_ok),
    .sub_hit  (sub_hit),
    .slot     (slot),
    .err_q    (err_out)
  );

  hdb3_sub_window #(.DEPTH(WIN_DEPTH)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_in (slot),
    .sub_hit (sub_hit),
    .pat_ok  (pat_ok),
    .nrz_q   (nrz_out)
  );
endmodule

// File: tb/tb_hdb3_ami_decoder.sv
module tb_hdb3_ami_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdb3_sel = 1'b1, loop_en = 1'b0;
  logic ext_pos = 1'b0, ext_neg = 1'b0, loc_pos = 1'b0, loc_neg = 1'b0;
  logic rclk_out, nrz_out, err_out;

  always #5 clk = ~clk;

  hdb3_ami_decoder dut (
    .clk(clk), .rst_n(rst_n), .hdb3_sel(hdb3_sel), .loop_en(loop_en),
    .ext_pos(ext_pos), .ext_neg(ext_neg), .loc_pos(loc_pos), .loc_neg(loc_neg),
    .rclk_out(rclk_out), .nrz_out(nrz_out), .err_out(err_out)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference state built from the requirements
  logic m_mark, m_viol;
  int   k;
  logic h_pl [16];
  logic h_d  [16];

  localparam int NBITS = 600;
  logic dat   [NBITS];
  logic enc_p [NBITS];
  logic enc_n [NBITS];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_mark = 1'b0; m_viol = 1'b0; k = 0;
    for (int i = 0; i < 16; i++) begin h_pl[i] = 1'b0; h_d[i] = 1'b0; end
  endfunction

  task automatic model_bit(input logic p, input logic n, input logic hdb3,
                           output logic e_err, output logic e_nrz);
    logic pat;
    e_err = 1'b0;
    e_nrz = h_d[(k - 4) & 15];
    h_pl[k & 15] = p | n;
    h_d[k & 15]  = 1'b0;
    if (p && n) begin
      h_d[k & 15] = 1'b1; e_err = 1'b1;
    end else if (p || n) begin
      if (p != m_mark) begin
        h_d[k & 15] = 1'b1; m_mark = p;
      end else if (!hdb3) begin
        h_d[k & 15] = 1'b1; e_err = 1'b1;
      end else begin
        pat = h_pl[(k - 4) & 15] && !h_pl[(k - 2) & 15] && !h_pl[(k - 1) & 15];
        if (pat) begin
          h_d[(k - 1) & 15] = 1'b0; h_d[(k - 2) & 15] = 1'b0; h_d[(k - 3) & 15] = 1'b0;
          e_err = (p == m_viol);
        end else begin
          h_d[k & 15] = 1'b1;
        end
        m_viol = p;
      end
    end
    k++;
  endtask

  // one symbol: drive after a falling edge, check after the next falling edge
  task automatic step(input string tag, input logic ep, input logic en,
                      input logic lp, input logic ln, input logic mode, input logic lpen);
    logic e_err, e_nrz, sp, sn;
    ext_pos = ep; ext_neg = en; loc_pos = lp; loc_neg = ln;
    hdb3_sel = mode; loop_en = lpen;
    #1;
    sp = lpen ? lp : ep;
    sn = lpen ? ln : en;
    chk(lpen ? "R3" : "R2", "rclk", rclk_out, sp | sn);
    model_bit(sp, sn, mode, e_err, e_nrz);
    @(negedge clk);
    chk(tag, "err", err_out, e_err);
    chk(tag, "nrz", nrz_out, e_nrz);
  endtask

  task automatic line(input string tag, input int sym, input logic mode);
    // sym: 0 space, 1 positive, 2 negative, 3 both
    step(tag, sym == 1 || sym == 3, sym == 2 || sym == 3, 1'b0, 1'b0, mode, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext_pos = 0; ext_neg = 0; loc_pos = 0; loc_neg = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "nrz in reset", nrz_out, 1'b0);
    chk("R10", "err in reset", err_out, 1'b0);
    model_clear();
    rst_n = 1'b1;
  endtask

  task automatic encode(input int n);
    logic last;
    int marks, i;
    last = 1'b0; marks = 0; i = 0;
    for (int j = 0; j < n; j++) begin enc_p[j] = 0; enc_n[j] = 0; end
    while (i < n) begin
      if (!dat[i] && i + 3 < n && !dat[i+1] && !dat[i+2] && !dat[i+3]) begin
        if (marks % 2 == 0) begin
          last = ~last;
          enc_p[i] = last; enc_n[i] = ~last;
        end
        enc_p[i+3] = last; enc_n[i+3] = ~last;
        marks = 0; i += 4;
      end else if (dat[i]) begin
        last = ~last;
        enc_p[i] = last; enc_n[i] = ~last;
        marks++; i++;
      end else begin
        i++;
      end
    end
  endtask

  task automatic run_encoded(input logic mode, input logic lpen, input string tag);
    logic rp, rn;
    for (int i = 0; i < NBITS; i++) dat[i] = ($urandom % 3 == 0);
    dat[0] = 1'b1;
    if (mode) encode(NBITS);
    else begin
      rp = 1'b0;
      for (int i = 0; i < NBITS; i++) begin
        if (dat[i]) rp = ~rp;
        enc_p[i] = dat[i] & rp; enc_n[i] = dat[i] & ~rp;
      end
    end
    do_reset();
    for (int i = 0; i < NBITS + 4; i++) begin
      rn = (i < NBITS);
      if (lpen)
        step(tag, $urandom % 2, $urandom % 2, rn && enc_p[i], rn && enc_n[i], mode, 1'b1);
      else
        step(tag, rn && enc_p[i], rn && enc_n[i], 1'b0, 1'b0, mode, 1'b0);
      if (i >= 4) chk(tag, "payload", nrz_out, dat[i-4]);
      chk(tag, "no error on legal code", err_out, 1'b0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d5b3));
    model_clear();
    // R10 reset state and initial polarities
    do_reset();
    line("R10", 2, 1'b0);  // negative first pulse = violation in AMI
    line("R10", 0, 1'b0);
    do_reset();
    line("R4", 1, 1'b0);   // positive first pulse is an ordinary mark
    line("R4", 2, 1'b0);
    line("R1", 0, 1'b0);
    line("R1", 0, 1'b0);
    line("R1", 0, 1'b0);
    line("R1", 0, 1'b0);
    // R5 anchor + 000V, then B00V, then a same-polarity substitution (R7)
    do_reset();
    line("R5", 1, 1'b1); line("R5", 0, 1'b1); line("R5", 0, 1'b1);
    line("R5", 0, 1'b1); line("R5", 1, 1'b1);
    line("R5", 2, 1'b1); line("R5", 0, 1'b1); line("R5", 0, 1'b1);
    line("R5", 2, 1'b1);
    line("R7", 0, 1'b1); line("R7", 0, 1'b1); line("R7", 0, 1'b1);
    line("R7", 2, 1'b1);
    for (int i = 0; i < 5; i++) line("R5", 0, 1'b1);
    // R6 violation with no anchor pulse
    do_reset();
    line("R6", 1, 1'b1); line("R6", 2, 1'b1); line("R6", 2, 1'b1);
    for (int i = 0; i < 5; i++) line("R6", 0, 1'b1);
    // R9 both rails, trackers untouched; R11 one-clock flag
    do_reset();
    line("R9", 3, 1'b0); line("R11", 0, 1'b0); line("R9", 1, 1'b0);
    line("R9", 3, 1'b1); line("R9", 2, 1'b1);
    for (int i = 0; i < 5; i++) line("R9", 0, 1'b1);
    // R8 AMI violation
    do_reset();
    line("R8", 1, 1'b0); line("R8", 1, 1'b0); line("R8", 0, 1'b0);
    for (int i = 0; i < 5; i++) line("R8", 0, 1'b0);
    // random raw symbols in both modes
    do_reset();
    for (int i = 0; i < 3000; i++)
      line(i < 1500 ? "R4" : "R7", $urandom % 4, i < 1500 ? 1'b0 : 1'b1);
    for (int i = 0; i < 1000; i++) line("R11", $urandom % 4, $urandom % 2);
    // legal streams end to end, direct and through the loop path
    run_encoded(1'b1, 1'b0, "R5");
    run_encoded(1'b1, 1'b1, "R3");
    run_encoded(1'b0, 1'b1, "R3");
    run_encoded(1'b0, 1'b0, "R4");
    finish_run();
  end
endmodule